// File: doc/BRIEF.md
# Pointer-Plus-Offset Instruction Executor

This block executes three single-word 16-bit instructions whose memory operand sits at a base pointer plus a small unsigned literal. The three instructions are an add of the working byte W to memory, a single-bit set, and a fill with all ones. The block holds W, a five-flag status byte and a 12-bit base pointer. It drives a simple 8-bit data memory port with an address, read data, write data and a write enable.

Instruction words arrive on a valid/ready stream. Each accepted word takes exactly four clock cycles, one per phase, in a fixed order:

- decode and address generation;
- operand read;
- compute;
- write-back.

W and the base pointer can also be loaded directly through plain control pins. A word that is not one of the three forms, or that names an offset above 95, is retired without effect and flagged with a strobe.

Back-pressure works as follows. `instr_ready` is high while the unit is idle and during the write-back phase of the current instruction. A word is taken on any rising edge where both `instr_valid` and `instr_ready` are high. While `instr_valid` is high and `instr_ready` is low, the producer must hold `instr_word` stable. There is no output stream; results appear in memory and in W and the status pins.

Top module: `idx_exec_unit`

## Requirements
- R1: After reset, `w_out`, `status_out` and `base_out` are zero, `mem_we`, `done` and `illegal` are low, and `instr_ready` is high.
- R2: The operand address is (base + k) modulo 4096, where k is `instr_word[7:0]`. The address is presented on `mem_addr` from the read phase through the write-back phase, and it holds steady across them.
- R3: A word matching 0010 01d0 kkkk kkkk with d=0 adds W to the addressed byte, puts the 8-bit sum in W and does not write memory.
- R4: The same add with d=1 (bit 9 set) writes the sum to the addressed byte and leaves W unchanged.
- R5: The add updates `status_out` as {N, OV, Z, DC, C} in bits 4 down to 0:
  - C is the carry out of bit 7.
  - DC is the carry out of bit 3.
  - OV is signed overflow.
  - N is bit 7 of the sum.
  - Z is high when the sum is zero.
- R6: A word matching 1000 bbb0 kkkk kkkk writes the addressed byte with bit b (`instr_word[11:9]`) forced to 1. It changes neither W nor the flags.
- R7: The word 0110 1000 kkkk kkkk writes FFh to the addressed byte and changes neither W nor the flags.
- R8: A word matching none of the three forms, or with k greater than 95, raises `illegal` together with `done`. Memory is not written, and W and the flags keep their values; k = 95 is still legal.
- R9: An instruction accepted on edge n shows `done` in the fourth cycle after that edge. `mem_we` is high only in that cycle, `instr_ready` is high in that cycle, and the next word may be accepted there with no gap.
- R10: `w_load` and `base_load` load W and the base pointer on the next edge. If an add with d=0 writes W in the same cycle that `w_load` is high, the add result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit can take a word this cycle |
| instr_word | input | 16 | Instruction word |
| w_load | input | 1 | Load W from `w_load_val` |
| w_load_val | input | 8 | Value for W |
| base_load | input | 1 | Load base pointer from `base_load_val` |
| base_load_val | input | 12 | Value for the base pointer |
| mem_addr | output | 12 | Data memory address |
| mem_rdata | input | 8 | Data memory read data, valid in the same cycle as the address |
| mem_wdata | output | 8 | Data memory write data |
| mem_we | output | 1 | Data memory write enable |
| w_out | output | 8 | Current W |
| status_out | output | 5 | Flags {N, OV, Z, DC, C} |
| base_out | output | 12 | Current base pointer |
| done | output | 1 | Write-back phase of an instruction |
| illegal | output | 1 | The retiring word was rejected |

## Verification
Two functions can land in the same cycle.

The first pair is the write of an add with d=0 into W and an external load of W. The bench counts three cycles forward from the add's acceptance, raises `w_load` in that add's write-back cycle, and then expects W to hold the sum rather than the loaded value.

The second pair is the retirement of one instruction and the acceptance of the next. The bench keeps `instr_valid` high across a chain of dependent instructions, so that each new word is taken in the previous word's write-back cycle. It then judges that every read sees the byte written just before it, and that each `done` falls exactly four cycles after its own acceptance.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 12;
  localparam int INSTR_W = 16;
  localparam int OFS_W   = 8;
  localparam int BSEL_W  = $clog2(DATA_W);
  localparam int FLAG_W  = 5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEC,
    PH_RD,
    PH_PROC,
    PH_WR
  } phase_t;

  typedef enum logic [1:0] {
    OP_ADD,
    OP_BSET,
    OP_FILL,
    OP_BAD
  } op_t;

  typedef struct packed {
    op_t               op;
    logic              to_mem;
    logic [BSEL_W-1:0] bitsel;
    logic [OFS_W-1:0]  ofs;
    logic              bad;
  } dec_t;

  // packed order puts n in bit 4 and c in bit 0
  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/idx_decoder.sv
module idx_decoder
  import idx_pkg::*;
#(
  parameter int K_MAX = 95
) (
  input  logic [INSTR_W-1:0] word,
  output dec_t               dec
);
  logic is_add, is_bset, is_fill;

  always_comb begin
    is_add  = (word[15:10] == 6'b001001) && !word[8];
    is_bset = (word[15:12] == 4'b1000) && !word[8];
    is_fill = (word[15:8] == 8'h68);

    dec.ofs    = word[OFS_W-1:0];
    dec.bitsel = word[11:9];
    dec.to_mem = 1'b1;
    dec.op     = OP_BAD;

    if (is_add) begin
      dec.op     = OP_ADD;
      dec.to_mem = word[9];
    end else if (is_bset) begin
      dec.op = OP_BSET;
    end else if (is_fill) begin
      dec.op = OP_FILL;
    end

    dec.bad = (dec.op == OP_BAD) || (int'(dec.ofs) > K_MAX);
  end
endmodule

// File: rtl/idx_agen.sv
module idx_agen
  import idx_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] ea
);
  localparam int PAD_W = ADDR_W - OFS_W;

  // unsigned offset, sum truncated to the address width (wraps)
  always_comb begin
    ea = base + {{PAD_W{1'b0}}, ofs};
  end
endmodule

// File: rtl/idx_alu.sv
module idx_alu
  import idx_pkg::*;
(
  input  op_t               op,
  input  logic [BSEL_W-1:0] bitsel,
  input  logic [DATA_W-1:0] w,
  input  logic [DATA_W-1:0] m,
  input  flags_t            flags_in,
  output logic [DATA_W-1:0] result,
  output flags_t            flags_out
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] bit_mask;
  logic [DATA_W:0]   full_sum;
  logic [NIB_W:0]    low_sum;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign bit_mask[i] = (bitsel == i[BSEL_W-1:0]);
  end

  always_comb begin
    full_sum  = {1'b0, w} + {1'b0, m};
    low_sum   = {1'b0, w[NIB_W-1:0]} + {1'b0, m[NIB_W-1:0]};
    result    = m;
    flags_out = flags_in;

    unique case (op)
      OP_ADD: begin
        result       = full_sum[DATA_W-1:0];
        flags_out.c  = full_sum[DATA_W];
        flags_out.dc = low_sum[NIB_W];
        flags_out.n  = full_sum[DATA_W-1];
        flags_out.z  = (full_sum[DATA_W-1:0] == '0);
        flags_out.ov = (w[DATA_W-1] == m[DATA_W-1]) &&
                       (full_sum[DATA_W-1] != w[DATA_W-1]);
      end
      OP_BSET: result = m | bit_mask;
      OP_FILL: result = '1;
      default: result = m;
    endcase
  end
endmodule

// File: rtl/idx_phase_seq.sv
module idx_phase_seq
  import idx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  output logic   accept,
  output phase_t phase
);
  phase_t next_phase;

  always_comb begin
    in_ready = (phase == PH_IDLE) || (phase == PH_WR);
    accept   = in_valid && in_ready;

    unique case (phase)
      PH_IDLE: next_phase = in_valid ? PH_DEC : PH_IDLE;
      PH_DEC:  next_phase = PH_RD;
      PH_RD:   next_phase = PH_PROC;
      PH_PROC: next_phase = PH_WR;
      PH_WR:   next_phase = in_valid ? PH_DEC : PH_IDLE;
      default: next_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= next_phase;
  end
endmodule

// File: rtl/idx_exec_unit.sv
module idx_exec_unit
  import idx_pkg::*;
#(
  parameter int K_MAX = 95
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  output logic                instr_ready,
  input  logic [INSTR_W-1:0]  instr_word,
  input  logic                w_load,
  input  logic [DATA_W-1:0]   w_load_val,
  input  logic                base_load,
  input  logic [ADDR_W-1:0]   base_load_val,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [DATA_W-1:0]   w_out,
  output logic [FLAG_W-1:0]   status_out,
  output logic [ADDR_W-1:0]   base_out,
  output logic                done,
  output logic                illegal
);
  phase_t              phase;
  logic                accept;
  logic [INSTR_W-1:0]  instr_q;
  dec_t                dec_now, dec_q;
  logic [ADDR_W-1:0]   ea_now, ea_q;
  logic [DATA_W-1:0]   rd_q, res_now, res_q;
  flags_t              flg_now, flg_q, status_q;
  logic [DATA_W-1:0]   w_q;
  logic [ADDR_W-1:0]   base_q;
  logic                retire_ok, w_from_add, flags_upd;

  idx_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (instr_valid),
    .in_ready (instr_ready),
    .accept   (accept),
    .phase    (phase)
  );

  idx_decoder #(.K_MAX(K_MAX)) u_dec (
    .word (instr_q),
    .dec  (dec_now)
  );

  idx_agen u_agen (
    .base (base_q),
    .ofs  (dec_now.ofs),
    .ea   (ea_now)
  );

  idx_alu u_alu (
    .op        (dec_q.op),
    .bitsel    (dec_q.bitsel),
    .w         (w_q),
    .m         (rd_q),
    .flags_in  (status_q),
    .result    (res_now),
    .flags_out (flg_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) instr_q <= '0;
    else if (accept) instr_q <= instr_word;
  end

  // per-phase pipeline registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q <= '0;
      ea_q  <= '0;
      rd_q  <= '0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      unique case (phase)
        PH_DEC: begin
          dec_q <= dec_now;
          ea_q  <= ea_now;
        end
        PH_RD:   rd_q <= mem_rdata;
        PH_PROC: begin
          res_q <= res_now;
          flg_q <= flg_now;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    retire_ok  = (phase == PH_WR) && !dec_q.bad;
    w_from_add = retire_ok && (dec_q.op == OP_ADD) && !dec_q.to_mem;
    flags_upd  = retire_ok && (dec_q.op == OP_ADD);
  end

  // architectural state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q      <= '0;
      status_q <= '0;
      base_q   <= '0;
    end else begin
      if (w_from_add)  w_q <= res_q;
      else if (w_load) w_q <= w_load_val;
      if (flags_upd)   status_q <= flg_q;
      if (base_load)   base_q <= base_load_val;
    end
  end

  always_comb begin
    mem_addr   = ea_q;
    mem_wdata  = res_q;
    mem_we     = retire_ok && ((dec_q.op != OP_ADD) || dec_q.to_mem);
    done       = (phase == PH_WR);
    illegal    = done && dec_q.bad;
    w_out      = w_q;
    status_out = status_q;
    base_out   = base_q;
  end
endmodule

// File: rtl/idx_exec_unit_chk.sv
module idx_exec_unit_chk
  import idx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_ready,
  input logic              w_load,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] w_out,
  input logic [FLAG_W-1:0] status_out,
  input logic              done,
  input logic              illegal
);
  // R9: retirement never repeats on consecutive cycles
  p_done_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: write-back phase always leaves room for the next word
  p_ready_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> instr_ready);

  // R8: rejected words never write memory
  p_illegal_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_we);

  // R8: rejected words leave W and flags alone
  p_illegal_keeps_w_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !w_load) |=> (w_out == $past(w_out)));

  p_illegal_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (status_out == $past(status_out)));

  // R2: address is unchanged between compute and write-back
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(mem_addr));

  // R4 / R6 / R7: a memory-writing retirement never changes W
  p_memwrite_keeps_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !w_load) |=> (w_out == $past(w_out)));
endmodule

bind idx_exec_unit idx_exec_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .w_load      (w_load),
  .mem_addr    (mem_addr),
  .mem_we      (mem_we),
  .w_out       (w_out),
  .status_out  (status_out),
  .done        (done),
  .illegal     (illegal)
);

// File: tb/idx_exec_unit_bench.sv
module idx_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = '0;
  logic        w_load = 1'b0;
  logic [7:0]  w_load_val = '0;
  logic        base_load = 1'b0;
  logic [11:0] base_load_val = '0;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  w_out;
  logic [4:0]  status_out;
  logic [11:0] base_out;
  logic        done;
  logic        illegal;

  always #10 clk = ~clk; // 50 MHz

  idx_exec_unit u_idx_exec_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .w_load(w_load), .w_load_val(w_load_val),
    .base_load(base_load), .base_load_val(base_load_val), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we), .w_out(w_out),
    .status_out(status_out), .base_out(base_out), .done(done), .illegal(illegal)
  );

  // data memory seen by the design, and the bench's own reference copy
  logic [7:0] dmem [4096];
  logic [7:0] ref_mem [4096];
  assign mem_rdata = dmem[mem_addr];
  always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

  typedef struct {
    logic        we;
    logic [11:0] addr;
    logic [7:0]  data;
    logic        bad;
    logic [7:0]  w;
    logic [4:0]  st;
    int          at_cyc;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  int          acc_q[$];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  logic [7:0]  m_w = '0;
  logic [4:0]  m_st = '0;
  logic [11:0] m_base = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  task automatic issue(input logic [15:0] word, input string req);
    exp_t e;
    logic [11:0] ea;
    logic [7:0]  k, m, r;
    logic [8:0]  s;
    logic [4:0]  ls;
    bit add_f, bset_f, fill_f;
    k      = word[7:0];
    ea     = m_base + {4'b0, k};
    m      = ref_mem[ea];
    add_f  = word[15:10] == 6'b001001 && !word[8];
    bset_f = word[15:12] == 4'b1000 && !word[8];
    fill_f = word[15:8] == 8'h68;
    e.req  = req;
    e.addr = ea;
    e.we   = 1'b0;
    e.data = 8'h00;
    e.bad  = (!add_f && !bset_f && !fill_f) || (k > 8'd95);
    if (!e.bad) begin
      if (add_f) begin
        s  = {1'b0, m_w} + {1'b0, m};
        ls = {1'b0, m_w[3:0]} + {1'b0, m[3:0]};
        r  = s[7:0];
        m_st = {r[7], (m_w[7] == m[7]) && (r[7] != m_w[7]), r == 8'h00, ls[4], s[8]};
        if (word[9]) begin e.we = 1'b1; e.data = r; end
        else m_w = r;
      end else if (bset_f) begin
        e.we = 1'b1; e.data = m | (8'h01 << word[11:9]);
      end else begin
        e.we = 1'b1; e.data = 8'hFF;
      end
      if (e.we) ref_mem[ea] = e.data;
    end
    e.w  = m_w;
    e.st = m_st;
    exp_q.push_back(e);
    instr_word  = word;
    instr_valid = 1'b1;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic load_w(input logic [7:0] v);
    w_load_val = v; w_load = 1'b1; m_w = v;
    @(negedge clk); w_load = 1'b0;
  endtask

  task automatic load_base(input logic [11:0] v);
    base_load_val = v; base_load = 1'b1; m_base = v;
    @(negedge clk); base_load = 1'b0;
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] v);
    dmem[a] = v; ref_mem[a] = v;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // monitor: pops expectations as instructions retire
  initial begin
    exp_t cur;
    bit   pend = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (pend) begin
          check(w_out == cur.w, {cur.req, " W"}, w_out, cur.w);
          check(status_out == cur.st, {cur.req, " flags"}, status_out, cur.st);
          pend = 1'b0;
        end
        if (mem_we && !done) check(1'b0, "R9 write outside write-back", 1, 0);
        if (done) begin
          if (exp_q.size() == 0) check(1'b0, "R9 unexpected retire", 1, 0);
          else begin
            cur = exp_q.pop_front();
            if (acc_q.size() != 0) begin
              int due;
              due = acc_q.pop_front();
              check(cyc == due, "R9 retire cycle", cyc, due);
            end
            check(instr_ready, "R9 ready at write-back", instr_ready, 1);
            check(illegal == cur.bad, {cur.req, " R8 illegal"}, illegal, cur.bad);
            check(mem_we == cur.we, {cur.req, " write enable"}, mem_we, cur.we);
            if (cur.we) begin
              check(mem_addr == cur.addr, {cur.req, " R2 address"}, mem_addr, cur.addr);
              check(mem_wdata == cur.data, {cur.req, " write data"}, mem_wdata, cur.data);
            end
            pend = 1'b1;
          end
        end
        if (instr_valid && instr_ready) acc_q.push_back(cyc + 4);
      end
    end
  end

  initial begin
    #(20 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin dmem[i] = 8'h00; ref_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(w_out == 0 && status_out == 0 && base_out == 0, "R1 state", {w_out, status_out}, 0);
    check(!mem_we && !done && !illegal && instr_ready, "R1 controls",
          {mem_we, done, illegal, instr_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 loads
    load_base(12'hA00);
    load_w(8'h17);
    check(base_out == 12'hA00, "R10 base load", base_out, 12'hA00);
    check(w_out == 8'h17, "R10 W load", w_out, 8'h17);

    // R3 add to W: 17h + 20h = 37h, no write
    poke(12'hA2C, 8'h20);
    issue(16'h242C, "R3 add to W");
    settle();
    check(dmem[12'hA2C] == 8'h20, "R3 memory untouched", dmem[12'hA2C], 8'h20);

    // R6 bit 7 set: 55h -> D5h
    poke(12'hA0A, 8'h55);
    issue(16'h8E0A, "R6 bit set");
    settle();
    check(dmem[12'hA0A] == 8'hD5, "R6 result", dmem[12'hA0A], 8'hD5);

    // R7 fill
    issue(16'h682C, "R7 fill");
    settle();
    // R4 / R5 add to memory: 37h + FFh
    issue(16'h262C, "R4 add to memory R5");
    settle();
    check(dmem[12'hA2C] == 8'h36, "R4 stored sum", dmem[12'hA2C], 8'h36);

    // R5 zero, carry and overflow: 80h + 80h
    load_w(8'h80);
    poke(12'hA10, 8'h80);
    issue(16'h2410, "R5 zero overflow");
    settle();
    // R5 negative overflow and half carry: 7Fh + 01h
    load_w(8'h7F);
    poke(12'hA11, 8'h01);
    issue(16'h2411, "R5 negative overflow");
    settle();
    // R6 flags unchanged with nonzero flags, bit 0
    poke(12'hA12, 8'h00);
    issue(16'h8012, "R6 flags kept");
    settle();

    // R8 boundaries and bad patterns
    issue(16'h245F, "R8 k=95 legal");
    settle();
    issue(16'h2460, "R8 k=96");
    settle();
    issue(16'hFFFF, "R8 bad opcode");
    settle();
    issue(16'h2500, "R8 bit8 set in add");
    settle();

    // R2 wrap modulo 4096
    load_base(12'hFF0);
    poke(12'h010, 8'h0F);
    issue(16'h6820, "R2 wrap fill");
    settle();
    check(dmem[12'h010] == 8'hFF, "R2 wrapped write", dmem[12'h010], 8'hFF);

    // R9 back-to-back dependent chain, each word taken at previous write-back
    load_base(12'h300);
    load_w(8'h01);
    poke(12'h305, 8'h00);
    issue(16'h8205, "R9 chain bset1");
    issue(16'h2605, "R9 chain add mem");
    issue(16'h2405, "R9 chain add W");
    issue(16'h6805, "R9 chain fill");
    issue(16'h2405, "R9 chain add W2");
    settle();

    // R10 conflict: W write-back of add and w_load in the same cycle
    load_w(8'h10);
    poke(12'h320, 8'h05);
    issue(16'h2420, "R10 add wins");
    repeat (3) @(negedge clk);
    w_load_val = 8'hAA; w_load = 1'b1;
    @(negedge clk);
    w_load = 1'b0;
    check(w_out == 8'h15, "R10 add beats load", w_out, 8'h15);
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule